// File: doc/BRIEF.md
# Call-Waiting Alert Qualifier

This controller decides whether a dual-tone alert burst heard during a call that is already in progress is a genuine start of a call-waiting caller-ID exchange. It watches the detect output of an external tone and level detector and counts millisecond ticks. First it measures how long the detect pulse lasts. While it measures, it mutes the local speech path so that near-end talk cannot imitate the tone. A pulse of acceptable width is then confirmed by a silent interval. During that interval the detector is switched to its FSK energy mode, so any far-end speech shows up as renewed detect activity.

Two timing options are available, selected by one input. In the handset option, muting starts as soon as the pulse is seen and the shortest valid pulse is 15 ms. In the external-box option, muting waits 15 ms and the shortest valid pulse is 30 ms. A confirmed alert raises a one-cycle indication. Muting and FSK mode are then held until the rest of the exchange reports that it is finished.

Top module: `cwalert_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mute`, `fsk_mode` and `alert_valid` are all 0.
- R2: `det_in` passes through a two-flop synchronizer before the controller acts on it. A rising `det_in` cannot assert `mute` within the first three clock edges that follow it. With `opt_adjunct`=0 it asserts `mute` on the fourth edge.
- R3: The mute delay T1 is 0 ticks when `opt_adjunct`=0 and 15 ticks when `opt_adjunct`=1. A detect pulse that ends before T1 ticks have been counted never asserts `mute`. A pulse still high when the count reaches T1 asserts `mute`.
- R4: The minimum valid width T3 is 15 ticks when `opt_adjunct`=0 and 30 ticks when `opt_adjunct`=1. If detect falls after `mute` is set but with fewer than T3 ticks counted since it rose, `mute` drops and `fsk_mode` stays 0.
- R5: If detect falls with a count from T3 to 64 ticks, `fsk_mode` goes to 1, `mute` stays 1 and the quiet timer restarts from zero.
- R6: If the count reaches 65 ticks while detect is still high, `mute` drops, `fsk_mode` stays 0 and no alert is raised. The controller then waits for detect to fall before it watches for a new pulse.
- R7: During the quiet interval, a rising detect seen with fewer than 50 ticks counted drops `mute` and `fsk_mode` and raises no alert.
- R8: When 50 quiet ticks have been counted, `alert_valid` pulses high for exactly one cycle. `mute` and `fsk_mode` then stay at 1.
- R9: If detect is seen high in the same cycle that the quiet count first shows 50, the rejection of R7 takes precedence and no alert is raised.
- R10: After an alert, detect activity is ignored, and `xact_done` drops `mute` and `fsk_mode`. While the quiet check is still running, `xact_done` has no effect.
- R11: The tick counter saturates at its maximum value instead of wrapping. A detect held high for far longer than the counter range still leaves `mute` at 0 and `fsk_mode` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_in | input | 1 | Detect output of the tone/level detector, asynchronous |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| opt_adjunct | input | 1 | 0 selects handset timing, 1 selects external-box timing |
| xact_done | input | 1 | Pulse marking the end of the caller-ID exchange |
| mute | output | 1 | Mute the local speech path |
| fsk_mode | output | 1 | 1 selects FSK energy detection, 0 selects tone-alert detection |
| alert_valid | output | 1 | One-cycle pulse when an alert is confirmed |

## Verification
During the quiet interval, a new detect rise and the expiry of the 50-tick count can arrive on the same clock edge. The bench provokes this by timing `det_in` against the fiftieth tick so that the synchronized detect becomes visible in exactly that cycle. It expects a rejection with no alert. It then moves the rise one cycle later and expects the alert, with muting held. Pulse-width sweeps from 0 to 70 ticks under both timing options, and a sweep of the quiet interval, check every boundary against arithmetic thresholds.

// File: rtl/cwalert_ctrl.sv
module cwalert_ctrl #(
  parameter int TMR_W   = 7,
  parameter int T1_BOX  = 15,
  parameter int T3_SET  = 15,
  parameter int T3_BOX  = 30,
  parameter int T_LONG  = 65,
  parameter int T_QUIET = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_in,
  input  logic ms_tick,
  input  logic opt_adjunct,
  input  logic xact_done,
  output logic mute,
  output logic fsk_mode,
  output logic alert_valid
);

  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};
  localparam logic [TMR_W-1:0] L_T1B   = TMR_W'(T1_BOX);
  localparam logic [TMR_W-1:0] L_T3S   = TMR_W'(T3_SET);
  localparam logic [TMR_W-1:0] L_T3B   = TMR_W'(T3_BOX);
  localparam logic [TMR_W-1:0] L_LONG  = TMR_W'(T_LONG);
  localparam logic [TMR_W-1:0] L_QUIET = TMR_W'(T_QUIET);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_MEAS, S_QUIET, S_DONE, S_DRAIN} state_t;

  state_t state, nxt;
  logic [1:0] sync;
  logic [TMR_W-1:0] tmr;
  logic det_s, clr, alert_q;
  logic [TMR_W-1:0] t1_lim, t3_lim;

  assign det_s  = sync[1];
  assign t1_lim = opt_adjunct ? L_T1B : '0;
  assign t3_lim = opt_adjunct ? L_T3B : L_T3S;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], det_in};
  end

  always_comb begin
    nxt = state;
    clr = 1'b0;
    case (state)
      S_IDLE: begin
        clr = 1'b1;
        if (det_s) nxt = S_ARM;
      end
      S_ARM: begin
        if (!det_s)              nxt = S_IDLE;
        else if (tmr >= t1_lim)  nxt = S_MEAS;
      end
      S_MEAS: begin
        if (!det_s) begin
          if (tmr < t3_lim) nxt = S_IDLE;
          else begin
            nxt = S_QUIET;
            clr = 1'b1;
          end
        end else if (tmr >= L_LONG) nxt = S_DRAIN;
      end
      S_QUIET: begin
        if (det_s)                nxt = S_IDLE;
        else if (tmr >= L_QUIET)  nxt = S_DONE;
      end
      S_DONE:  if (xact_done) nxt = S_IDLE;
      S_DRAIN: if (!det_s)    nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tmr     <= '0;
      alert_q <= 1'b0;
    end else begin
      state   <= nxt;
      alert_q <= (state == S_QUIET) && (nxt == S_DONE);
      if (clr)                           tmr <= '0;
      else if (ms_tick && tmr != TMR_MAX) tmr <= tmr + 1'b1;
    end
  end

  assign mute        = (state == S_MEAS) || (state == S_QUIET) || (state == S_DONE);
  assign fsk_mode    = (state == S_QUIET) || (state == S_DONE);
  assign alert_valid = alert_q;

  AST_ALERT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_valid |=> !alert_valid); // R8
  AST_ALERT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_valid |-> (mute && fsk_mode)); // R8
  AST_FSK_AFTER_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsk_mode) |-> $past(mute)); // R5
  AST_LONG_UNMUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MEAS && det_s && tmr >= L_LONG) |=> (!mute && !fsk_mode)); // R6
  AST_QUIET_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_QUIET && det_s) |=> (!fsk_mode && !alert_valid)); // R9
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && xact_done) |=> !mute); // R10
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr == TMR_MAX && !clr) |=> tmr == TMR_MAX); // R11

endmodule

// File: tb/tb_cwalert_ctrl.sv
`timescale 1ns/1ps
module tb_cwalert_ctrl;
  localparam int TP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_in = 1'b0, ms_tick = 1'b0, opt_adjunct = 1'b0, xact_done = 1'b0;
  logic mute, fsk_mode, alert_valid;
  int total = 0, fails = 0, acnt = 0;

  cwalert_ctrl dut (
    .clk(clk), .rst_n(rst_n), .det_in(det_in), .ms_tick(ms_tick),
    .opt_adjunct(opt_adjunct), .xact_done(xact_done),
    .mute(mute), .fsk_mode(fsk_mode), .alert_valid(alert_valid)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (alert_valid) acnt++;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic t);
    @(negedge clk);
    ms_tick = t;
  endtask

  task automatic idle(int n);
    repeat (n) cyc(1'b0);
  endtask

  task automatic ms();
    repeat (TP-1) cyc(1'b0);
    cyc(1'b1);
  endtask

  task automatic done_pulse();
    xact_done = 1'b1;
    idle(1);
    xact_done = 1'b0;
  endtask

  task automatic enter_quiet(bit adj, int w);
    opt_adjunct = adj;
    det_in = 1'b1;
    idle(4);
    repeat (w) ms();
    idle(3);
    det_in = 1'b0;
    idle(5);
  endtask

  task automatic clean();
    det_in = 1'b0;
    idle(4);
    done_pulse();
    idle(4);
    acnt = 0;
  endtask

  task automatic pulse_trial(bit adj, int w);
    int t1, t3;
    bit exp_m, acc;
    t1 = adj ? 15 : 0;
    t3 = adj ? 30 : 15;
    acnt = 0;
    opt_adjunct = adj;
    det_in = 1'b1;
    idle(4);
    repeat (w) ms();
    idle(3);
    exp_m = (w >= t1) && (w < 65);
    chk(w < 65 ? "R3 mute during pulse" : "R6 mute after overlong", int'(mute), int'(exp_m));
    chk("R4 tone mode during pulse", int'(fsk_mode), 0);
    det_in = 1'b0;
    idle(5);
    acc = (w >= t3) && (w < 65);
    chk(acc ? "R5 mute after accepted" : "R4 mute after rejected", int'(mute), int'(acc));
    chk(acc ? "R5 fsk after accepted" : "R4 fsk after rejected", int'(fsk_mode), int'(acc));
    if (acc) begin
      done_pulse();
      chk("R10 xact_done ignored in quiet", int'(mute && fsk_mode), 1);
      repeat (49) ms();
      idle(3);
      chk("R8 no alert at 49", acnt, 0);
      ms();
      idle(3);
      chk("R8 alert count", acnt, 1);
      chk("R8 mute/fsk held", int'(mute && fsk_mode), 1);
      det_in = 1'b1;
      idle(5);
      chk("R10 detect ignored after alert", int'(mute), 1);
      det_in = 1'b0;
      idle(3);
      done_pulse();
      idle(2);
      chk("R10 exit mute", int'(mute), 0);
      chk("R10 exit fsk", int'(fsk_mode), 0);
      chk("R8 single pulse", acnt, 1);
    end else begin
      chk(w >= 65 ? "R6 no alert" : "R4 no alert", acnt, 0);
    end
    clean();
  endtask

  initial begin
    #1_500_000;
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 mute in reset", int'(mute), 0);
    chk("R1 fsk in reset", int'(fsk_mode), 0);
    chk("R1 alert in reset", int'(alert_valid), 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 mute after reset", int'(mute), 0);
    idle(3);

    opt_adjunct = 1'b0;
    det_in = 1'b1;
    idle(3);
    chk("R2 sync latency", int'(mute), 0);
    idle(1);
    chk("R2 mute after sync", int'(mute), 1);
    clean();

    for (int a = 0; a < 2; a++)
      for (int w = 0; w <= 70; w++)
        pulse_trial(a[0], w);

    for (int q = 0; q < 52; q++) begin
      enter_quiet(1'b1, 40);
      repeat (q) ms();
      det_in = 1'b1;
      idle(5);
      if (q < 50) begin
        chk("R7 reject mute", int'(mute), 0);
        chk("R7 reject fsk", int'(fsk_mode), 0);
        chk("R7 no alert", acnt, 0);
      end else begin
        chk("R8 alert before late rise", acnt, 1);
        chk("R10 rise ignored", int'(mute && fsk_mode), 1);
      end
      clean();
    end

    enter_quiet(1'b1, 40);
    repeat (49) ms();
    repeat (TP-1) cyc(1'b0);
    det_in = 1'b1;
    cyc(1'b1);
    idle(4);
    chk("R9 collision no alert", acnt, 0);
    chk("R9 collision unmute", int'(mute), 0);
    clean();

    enter_quiet(1'b1, 40);
    repeat (49) ms();
    repeat (TP-1) cyc(1'b0);
    cyc(1'b1);
    det_in = 1'b1;
    idle(4);
    chk("R9 late rise alert", acnt, 1);
    chk("R9 late rise mute", int'(mute), 1);
    clean();

    opt_adjunct = 1'b1;
    det_in = 1'b1;
    idle(4);
    repeat (200) ms();
    idle(3);
    chk("R11 long hold mute", int'(mute), 0);
    chk("R11 long hold fsk", int'(fsk_mode), 0);
    det_in = 1'b0;
    idle(5);
    chk("R11 recover idle", int'(mute), 0);
    clean();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule